// File: doc/BRIEF.md
# Cascaded Ring Delay Timer

The block emits a single-cycle completion pulse a fixed number of clock cycles, K, after it accepts a start strobe. K is set at elaboration time. No binary counter is compared against a wide terminal value. The timer is built from 16-position one-hot rings and from short token shift registers.

K is written in base 16. Ring number L advances only when every ring below it wraps. This gives a tick whose period is 16^L cycles. Each non-zero hex digit of K becomes a short run of token positions that advance on the tick of that digit's level. The token crosses the most significant digit's run first and the least significant digit's run last. The last step of the token raises the done pulse.

Only one timing event is in flight at a time. A start that arrives while the timer is running is dropped. A synchronous clear returns every ring and token position to idle.

Top module: `cascade_ring_timer`

## Requirements
- R1: When start is high in cycle c, the timer is idle and clear is low, done is high in cycle c+K. This holds for every K of 1 or more.
- R2: For K of 1 or more, done is high for exactly one cycle per accepted start and is never high at any other time.
- R3: For K of 1 or more, busy is high from cycle c+1 through cycle c+K inclusive, and low in every other cycle.
- R4: A start raised while busy is high is ignored. The done cycle of the event already running does not move, and no extra done pulse appears.
- R5: When clear is high in a cycle, busy is low from the next cycle on. The event that was in flight never produces done.
- R6: While clear is held, and after it is released with no start, done and busy are both low.
- R7: With K equal to 0, done equals start gated by clear in the same cycle, and busy stays low.
- R8: A start in the done cycle itself is ignored. The next start can be accepted one cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clear | input | 1 | Synchronous clear back to idle |
| start | input | 1 | Start strobe, used only while idle |
| done | output | 1 | One-cycle pulse K cycles after an accepted start |
| busy | output | 1 | An event is in flight |

## Verification
The bench sweeps K over 0, 1, 15, 16, 17, 255, 256 and 1000. These values sit on and around the points where a ring wraps or a hex digit becomes zero. A design that handed the token between levels one cycle late, or that let a token advance twice on a shared tick boundary, would miss these exact done cycles by one or by a whole 16^L period.

Starts held high across the done cycle catch a design that re-arms too early. Such a design would fire an extra done, or shorten the next interval for K equal to 1. A clear in mid-flight catches a design that leaves a stale token in a ring. That design would later raise a done that no start caused.

// File: rtl/cascade_ring_timer.sv
module cascade_ring_timer #(
  parameter int K = 1000
) (
  input  logic clk,
  input  logic clear,
  input  logic start,
  output logic done,
  output logic busy
);

  function automatic int ndig(input int k);
    int n;
    n = 0;
    while (k > 0) begin
      k = k / 16;
      n = n + 1;
    end
    return n;
  endfunction

  function automatic int digit(input int k, input int l);
    for (int i = 0; i < l; i++) k = k / 16;
    return k % 16;
  endfunction

  function automatic int ntok(input int k);
    int s;
    s = 0;
    while (k > 0) begin
      s = s + k % 16;
      k = k / 16;
    end
    return s;
  endfunction

  function automatic int lev(input int k, input int p);
    int acc, res;
    bit found;
    acc = 0;
    res = 0;
    found = 1'b0;
    for (int l = ndig(k) - 1; l >= 0; l--) begin
      acc = acc + digit(k, l);
      if (!found && p < acc) begin
        res = l;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  localparam int ND = ndig(K);
  localparam int NT = (ND > 0) ? ND : 1;
  localparam int M  = ntok(K);
  localparam int MW = (M > 0) ? M : 1;

  logic [NT-1:0] tick;
  logic [MW-1:0] tok;
  logic          go;

  assign busy    = |tok;
  assign go      = start & ~busy & ~clear;
  assign tick[0] = busy;

  for (genvar l = 0; l + 1 < ND; l++) begin : g_ring
    logic [15:0] ring;
    always_ff @(posedge clk) begin
      if (clear || go) ring <= 16'h0001;
      else if (tick[l]) ring <= {ring[14:0], ring[15]};
    end
    assign tick[l+1] = tick[l] & ring[15];
  end

  if (M == 0) begin : g_none
    assign tok  = '0;
    assign done = go;
  end else begin : g_tok
    for (genvar p = 0; p < M; p++) begin : g_pos
      localparam int LV = lev(K, p);
      logic t, enter;
      if (p == 0) begin : g_first
        assign enter = go;
      end else begin : g_next
        assign enter = tok[p-1] & tick[lev(K, p - 1)];
      end
      always_ff @(posedge clk) begin
        if (clear) t <= 1'b0;
        else       t <= enter | (t & ~tick[LV]);
      end
      assign tok[p] = t;
    end
    assign done = tok[M-1] & tick[lev(K, M - 1)];
  end

endmodule

// File: rtl/cascade_ring_timer_checker.sv
module cascade_ring_timer_checker #(
  parameter int K = 1000
) (
  input logic clk,
  input logic clear,
  input logic start,
  input logic done,
  input logic busy
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (clear)
    (K > 0) && done |=> !done); // R2

  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (clear)
    (K > 0) && done |-> busy); // R3

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (clear)
    (K > 0) && done |=> !busy); // R3

  AST_START_ARMS: assert property (@(posedge clk) disable iff (clear)
    (K > 0) && start && !busy |=> busy); // R1

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (clear)
    (K > 1) && busy && !done |=> busy); // R4

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (clear)
    $past(clear) |-> !busy); // R5

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (clear)
    (K == 0) |-> !busy); // R7

endmodule

bind cascade_ring_timer cascade_ring_timer_checker #(.K(K)) u_chk (
  .clk(clk), .clear(clear), .start(start), .done(done), .busy(busy)
);

// File: tb/cascade_ring_timer_test.sv
module cascade_ring_timer_test;

  localparam int NK = 8;
  localparam int KS [NK] = '{0, 1, 15, 16, 17, 255, 256, 1000};

  logic clk = 1'b0;
  logic clear = 1'b1;
  logic start = 1'b0;
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   over = 1'b0;
  string phase = "R6";

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int k, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s K=%0d cycle %0d: actual %0d expected %0d", tag, k, cyc, act, exp);
    end
  endtask

  for (genvar gi = 0; gi < NK; gi++) begin : g
    localparam int KV = KS[gi];
    logic done, busy;
    int   q[$];
    int   st = 0, en = 0;
    bit   act = 1'b0;

    cascade_ring_timer #(.K(KV)) uut (
      .clk(clk), .clear(clear), .start(start), .done(done), .busy(busy)
    );

    always @(negedge clk) begin
      bit eb, acc;
      string tg;
      eb  = act && cyc > st && cyc <= en;
      acc = !clear && start && !eb;
      if (KV == 0) begin
        chk(done == acc, "R7", KV, done, acc);
        chk(busy == 1'b0, "R7", KV, busy, 0);
      end else begin
        tg = (phase == "R1") ? "R3" : phase;
        chk(busy == eb, tg, KV, busy, eb);
        if (q.size() > 0 && q[0] < cyc) begin
          chk(1'b0, phase, KV, 0, q[0]);
          void'(q.pop_front());
        end
        if (done) begin
          if (q.size() > 0 && q[0] == cyc) begin
            chk(1'b1, phase, KV, cyc, q[0]);
            void'(q.pop_front());
          end else begin
            chk(1'b0, "R2", KV, cyc, (q.size() > 0) ? q[0] : -1);
          end
        end
      end
      if (clear) begin
        act = 1'b0;
        q.delete();
      end else if (acc) begin
        st  = cyc;
        en  = cyc + KV;
        act = 1'b1;
        if (KV > 0) q.push_back(en);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    step(3);
    clear = 1'b0;
    step(5);

    phase = "R1";
    pulse_start();
    step(1100);

    phase = "R4";
    pulse_start();
    step(2);
    pulse_start();
    step(300);
    pulse_start();
    step(1100);

    phase = "R8";
    start = 1'b1;
    step(2100);
    start = 1'b0;
    step(1100);

    phase = "R5";
    pulse_start();
    step(100);
    clear = 1'b1;
    step(1);
    clear = 1'b0;
    step(1100);

    phase = "R1";
    pulse_start();
    step(1100);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule